// File: doc/BRIEF.md
# Recent-ones window detector

This block watches a serial bit stream `x`, one bit per clock, and raises `z` whenever a 1 appears anywhere in a window made of the present bit and the three bits before it. It is a Mealy machine, so the present bit reaches `z` in the same cycle it is applied, with no register in between.

The window history is not kept as a shift register. It is folded into four states that record how many cycles have passed since the latest 1: none recent, one, two or three cycles ago. A 1 on the input always moves the machine back to the "one cycle ago" state. A run of zeros walks it down toward the idle state, where it then stays. An active-low asynchronous reset clears the history.

Top module: `recent_ones_detector`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released with `x`=0, `z` is 0. Reset clears all history of earlier 1s.
- R2: When `x` is 1, `z` is 1 in the same cycle, whatever the history.
- R3: After a single 1, `z` stays 1 for exactly the next three cycles with `x`=0. On the fourth consecutive 0 it returns to 0.
- R4: A 1 that arrives during a countdown restarts it. `z` then stays 1 for three further zero inputs, counted from that latest 1.
- R5: For any input stream, `z` in each cycle equals the OR of the present `x` and the previous three `x` values taken since reset.
- R6: From reset, the input sequence 1,0,0,1,0,0,0,0,0 gives the output sequence 1,1,1,1,1,1,1,0,0.
- R7: While `rst_n` is held low, `z` equals `x`, because no earlier input is remembered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x | input | 1 | Serial input bit |
| z | output | 1 | High when a 1 lies in the last four samples, present one included |

## Verification
The hardest condition to reach from the ports is a 1 that lands exactly on the last count before the idle state. If that 1 fails to restart the window, the machine drops to idle one cycle too early. The stimulus places a second 1 after one, two and then three zeros, and follows each with a long zero run so the exact cycle where `z` falls is visible. It also places reset in the middle of a countdown. After that it runs a long pseudo-random stream, with varied densities of 1s, against a four-sample window model.

// File: rtl/recent_ones_pkg.sv
package recent_ones_pkg;
    localparam int WINDOW   = 4;
    localparam int STATE_W  = $clog2(WINDOW);

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 2'd0,
        ST_AGO1  = 2'd1,
        ST_AGO2  = 2'd2,
        ST_AGO3  = 2'd3
    } age_t;

    typedef struct packed {
        age_t age;
    } regs_t;
endpackage

// File: rtl/ro_next_state.sv
module ro_next_state
    import recent_ones_pkg::*;
(
    input  age_t cur,
    input  logic x,
    output age_t nxt
);
    always_comb begin
        if (x) begin
            nxt = ST_AGO1;
        end else begin
            unique case (cur)
                ST_AGO1: nxt = ST_AGO2;
                ST_AGO2: nxt = ST_AGO3;
                ST_AGO3: nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ro_output.sv
module ro_output
    import recent_ones_pkg::*;
(
    input  age_t cur,
    input  logic x,
    output logic z
);
    always_comb begin
        z = x || (cur != ST_IDLE);
    end
endmodule

// File: rtl/recent_ones_detector.sv
module recent_ones_detector
    import recent_ones_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    output logic z
);
    regs_t r_q;
    regs_t r_d;
    age_t  age_nxt;

    ro_next_state i_next (
        .cur (r_q.age),
        .x   (x),
        .nxt (age_nxt)
    );

    ro_output i_out (
        .cur (r_q.age),
        .x   (x),
        .z   (z)
    );

    always_comb begin
        r_d     = r_q;
        r_d.age = age_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.age <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R1: first cycle out of reset starts from the idle state
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (r_q.age == ST_IDLE));

    // R2: a present 1 is visible on z at once
    a_r2_one_drives_z: assert property (@(posedge clk) disable iff (!rst_n)
        x |-> z);

    // R3: four quiet samples force z low
    a_r3_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!x && !$past(x) && !$past(x, 2) && !$past(x, 3)) |-> !z);

    // R3: countdown advances by one age per zero input
    a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.age == ST_AGO1 && !x) |=> (r_q.age == ST_AGO2));

    // R4: a 1 restarts the window from the latest sample
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && x) |=> (r_q.age == ST_AGO1 && z));
endmodule

// File: tb/test_recent_ones_detector.sv
module test_recent_ones_detector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x = 1'b0;
    logic z;

    int checks = 0;
    int errors = 0;
    logic [2:0] hist = 3'b000;

    always #5 clk = ~clk;

    recent_ones_detector i_recent_ones_detector (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (x),
        .z     (z)
    );

    task automatic check(input logic exp, input string tag);
        checks++;
        if (z !== exp) begin
            errors++;
            $display("FAIL %s: z=%b expected %b (time %0t)", tag, z, exp, $time);
        end
    endtask

    task automatic step(input logic xv, input string tag);
        @(negedge clk);
        x = xv;
        #1;
        check(xv | (|hist), tag);
        hist = {hist[1:0], xv};
    endtask

    task automatic step_exp(input logic xv, input logic exp, input string tag);
        @(negedge clk);
        x = xv;
        #1;
        check(exp, tag);
        hist = {hist[1:0], xv};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        x = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        hist = 3'b000;
    endtask

    task automatic t_reset();
        #1;
        check(1'b0, "R1 during reset");
        do_reset();
        step_exp(1'b0, 1'b0, "R1 first cycle after reset");
        step_exp(1'b0, 1'b0, "R1 idle stays idle");
    endtask

    task automatic t_single_one();
        do_reset();
        step_exp(1'b1, 1'b1, "R2 lone one");
        step_exp(1'b0, 1'b1, "R3 zero 1");
        step_exp(1'b0, 1'b1, "R3 zero 2");
        step_exp(1'b0, 1'b1, "R3 zero 3");
        step_exp(1'b0, 1'b0, "R3 zero 4");
        step_exp(1'b0, 1'b0, "R3 zero 5");
    endtask

    task automatic t_restart();
        for (int gap = 1; gap <= 3; gap++) begin
            do_reset();
            step_exp(1'b1, 1'b1, "R2 first one");
            for (int k = 0; k < gap; k++) step_exp(1'b0, 1'b1, "R4 gap");
            step_exp(1'b1, 1'b1, "R2 restart one");
            step_exp(1'b0, 1'b1, "R4 after restart 1");
            step_exp(1'b0, 1'b1, "R4 after restart 2");
            step_exp(1'b0, 1'b1, "R4 after restart 3");
            step_exp(1'b0, 1'b0, "R4 window ends");
        end
    endtask

    task automatic t_example();
        logic [8:0] xin  = 9'b100100000;
        logic [8:0] zout = 9'b111111100;
        do_reset();
        for (int i = 8; i >= 0; i--) step_exp(xin[i], zout[i], "R6 sequence");
    endtask

    task automatic t_reset_mid();
        do_reset();
        step(1'b1, "R5 before reset");
        step(1'b0, "R5 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        x = 1'b0;
        #1;
        check(1'b0, "R7 reset x=0");
        @(negedge clk);
        x = 1'b1;
        #1;
        check(1'b1, "R7 reset x=1");
        @(negedge clk);
        x = 1'b0;
        #1;
        check(1'b0, "R7 reset after x=1");
        rst_n = 1'b1;
        hist = 3'b000;
        step_exp(1'b0, 1'b0, "R1 history cleared");
    endtask

    task automatic t_random();
        do_reset();
        for (int blk = 0; blk < 4; blk++) begin
            for (int i = 0; i < 500; i++) begin
                logic b = ($urandom_range(0, 9) < (blk * 2 + 1));
                step(b, "R5 random");
            end
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_single_one();
        t_restart();
        t_example();
        t_reset_mid();
        t_random();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule